// File: doc/BRIEF.md
# SD Command Line Engine

This block drives one command frame onto the command line of an SD or MMC card and then collects the card's reply. A single start pulse takes a 6-bit command index, a 32-bit argument, a response length and three option flags. The block sends a 48-bit frame: a 0 start bit, a 1 direction bit, the index, the argument, a CRC7 it computes, and a 1 end bit. It then releases the line and listens for the card's start bit. Each clock cycle is one bit time; clock division belongs to the surrounding logic.

Once a start bit arrives, the block shifts in a programmed number of bits and checks them against CRC7. The check can be turned off, or made to begin at received bit 8 so that long replies can skip their fixed header. It can then hold completion while DAT0 is low (card busy). Completion raises a sticky interrupt together with status flags. Software reads the captured reply as 32-bit words through a read pointer that can be cleared and that advances after each read.

Top module: `sdcmd_engine`

## Requirements
- R1: A `start` pulse while idle makes `cmd_oe` go high from the next cycle for exactly 48 cycles. The first 40 bits on `cmd_out` are 0, 1, `cmd_idx` MSB first, then `cmd_arg` MSB first.
- R2: Bits 40 to 46 of the frame carry the CRC7 of the first 40 bits, MSB first. The CRC7 uses polynomial x^7+x^3+1 with an all-zero seed. Bit 47 is 1. Whenever `cmd_oe` is low, `cmd_out` is 1.
- R3: After the frame, the line is sampled for a 0 start bit for up to 64 cycles, and a start bit in the 64th sample is accepted. If none arrives, `st_timeout` and `irq_done` are set together and the engine returns to idle.
- R4: The engine captures `resp_len_m1`+1 bits, counting the start bit. Let captured bit 0 be the last bit received. Read word k (k = 0..3) holds captured bits 32k+39 down to 32k+8. `resp_ptr_clr` sets the pointer to word 0, and each `resp_rd` cycle advances it by one.
- R5: `st_crc_ok` is 1 when the CRC7 of the received bits, followed by the received 7-bit CRC, leaves a zero remainder. The CRC covers everything before the last 8 bits. It starts at bit 0, or at bit 8 when `opt_crc_from8` is set.
- R6: With `opt_skip_crc` set, `st_crc_ok` is 1 whatever CRC was received.
- R7: With `opt_busy_wait` set, `irq_done` stays low after the last response bit until `dat0_in` is sampled high. It rises one cycle after that sample.
- R8: `irq_done` stays set until an `irq_clr` cycle. A new completion in the same cycle as `irq_clr` wins over the clear.
- R9: A `start` pulse while `st_busy` is high is ignored: the frame being sent is not changed.
- R10: After reset, `st_busy`, `irq_done` and `cmd_oe` are 0 and `cmd_out` is 1. `st_busy` is high from the cycle after an accepted start until completion, and is low in the cycle `irq_done` is first seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (used only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_len_m1 | input | 8 | Response length in bits minus one |
| opt_skip_crc | input | 1 | Report CRC as good without checking |
| opt_crc_from8 | input | 1 | Begin the response CRC at received bit 8 |
| opt_busy_wait | input | 1 | Wait for DAT0 high before completing |
| irq_clr | input | 1 | Clear the done interrupt |
| resp_ptr_clr | input | 1 | Set the response read pointer to word 0 |
| resp_rd | input | 1 | Advance the response read pointer |
| resp_word | output | 32 | Response word at the read pointer |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line sampled value |
| dat0_in | input | 1 | DAT0 line sampled value |
| st_busy | output | 1 | Command in progress |
| st_crc_ok | output | 1 | Response CRC good (or skipped) |
| st_timeout | output | 1 | No response start bit seen |
| irq_done | output | 1 | Sticky completion interrupt |

## Verification
The transmit side is checked bit by bit under three patterns: a mixed argument, an all-zero argument with index 0, and an all-ones argument with index 63. Between them they expose a wrong field order, a wrong polynomial and a wrong seed. The receive side gets a 48-bit reply with a good CRC, the same reply with one CRC bit flipped (with and without the skip flag), and a 136-bit reply checked both from bit 8 and from bit 0. Only the start offset makes the long reply pass, and the word readback shows whether the captured bits line up. The start bit is sent once at the last accepted sample and once not at all, which pins the 64-cycle window to the exact cycle. A busy hold shows that completion waits for DAT0, and a start pulse during a frame shows that the frame is left alone.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_TX,
    S_WAIT,
    S_RX,
    S_BUSY
  } cmd_state_t;

  localparam int CRC_W   = 7;
  localparam int CRC_POLY = 7'h09;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             shift,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_q
);
  logic [CRC_W-1:0] crc_d;
  logic             fb;
  logic             en;

  always_comb begin
    fb    = bit_in ^ crc_q[CRC_W-1];
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (upd) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_W'(CRC_POLY) : '0);
    end else if (shift) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0};
    end
    en = clr | upd | shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (en) begin
      crc_q <= crc_d;
    end
  end
endmodule

// File: rtl/sdcmd_resp_store.sv
module sdcmd_resp_store #(
  parameter int RESP_MAX = 136,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_en,
  input  logic              bit_in,
  input  logic              ptr_clr,
  input  logic              rd,
  output logic [WORD_W-1:0] word_out
);
  localparam int SKIP  = 8;
  localparam int WORDS = (RESP_MAX - SKIP) / WORD_W;
  localparam int PTR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [RESP_MAX-1:0] cap_q;
  logic [PTR_W-1:0]    ptr_q;
  logic [PTR_W-1:0]    ptr_d;
  logic [WORD_W-1:0]   words [WORDS];

  genvar k;
  generate
    for (k = 0; k < WORDS; k++) begin : g_word
      assign words[k] = cap_q[WORD_W*k+SKIP +: WORD_W];
    end
  endgenerate

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_clr) begin
      ptr_d = '0;
    end else if (rd) begin
      ptr_d = (ptr_q == PTR_W'(WORDS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (clr) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= {cap_q[RESP_MAX-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_clr | rd) begin
      ptr_q <= ptr_d;
    end
  end

  assign word_out = words[ptr_q];
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int ARG_W       = 32,
  parameter int LEN_W       = 8,
  parameter int RESP_MAX    = 136,
  parameter int WORD_W      = 32,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic [LEN_W-1:0]  resp_len_m1,
  input  logic              opt_skip_crc,
  input  logic              opt_crc_from8,
  input  logic              opt_busy_wait,
  input  logic              irq_clr,
  input  logic              resp_ptr_clr,
  input  logic              resp_rd,
  output logic [WORD_W-1:0] resp_word,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in,
  input  logic              dat0_in,
  output logic              st_busy,
  output logic              st_crc_ok,
  output logic              st_timeout,
  output logic              irq_done
);
  localparam int HDR_BITS   = 2 + IDX_W + ARG_W;
  localparam int FRAME_BITS = HDR_BITS + CRC_W + 1;
  localparam int TO_W       = $clog2(TIMEOUT_CYC);
  localparam int FR_W       = $clog2(FRAME_BITS);
  localparam int CNT_W      = (LEN_W > TO_W) ? ((LEN_W > FR_W) ? LEN_W : FR_W)
                                             : ((TO_W > FR_W) ? TO_W : FR_W);

  // reset synchroniser: assert asynchronously, release on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  cmd_state_t          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [HDR_BITS-1:0] tx_q, tx_d;
  logic [LEN_W-1:0]    len_q, len_d;
  logic                skip_q, skip_d, from8_q, from8_d, bw_q, bw_d;
  logic                ok_q, ok_d, to_q, to_d, irq_q, irq_d;
  logic                finish;
  logic [CRC_W-1:0]    crc_q;
  logic                crc_clr, crc_upd, crc_shift, crc_bit;
  logic                cap_clr, cap_en;
  logic [CNT_W-1:0]    rx_first;

  sdcmd_crc7 u_crc (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (crc_clr),
    .upd   (crc_upd),
    .shift (crc_shift),
    .bit_in(crc_bit),
    .crc_q (crc_q)
  );

  sdcmd_resp_store #(.RESP_MAX(RESP_MAX), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (cap_clr),
    .cap_en  (cap_en),
    .bit_in  (cmd_in),
    .ptr_clr (resp_ptr_clr),
    .rd      (resp_rd),
    .word_out(resp_word)
  );

  // datapath controls
  always_comb begin
    rx_first  = from8_q ? CNT_W'(8) : CNT_W'(0);
    crc_clr   = ((state_q == S_IDLE) && start) || ((state_q == S_WAIT) && !cmd_in);
    crc_upd   = ((state_q == S_TX) && (cnt_q < CNT_W'(HDR_BITS))) ||
                ((state_q == S_RX) && (cnt_q >= rx_first) && (cnt_q < CNT_W'(len_q)));
    crc_shift = (state_q == S_TX) && (cnt_q >= CNT_W'(HDR_BITS)) &&
                (cnt_q < CNT_W'(HDR_BITS + CRC_W));
    crc_bit   = (state_q == S_TX) ? tx_q[HDR_BITS-1] : cmd_in;
    cap_clr   = (state_q == S_IDLE) && start;
    cap_en    = ((state_q == S_WAIT) && !cmd_in) || (state_q == S_RX);
  end

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tx_d    = tx_q;
    len_d   = len_q;
    skip_d  = skip_q;
    from8_d = from8_q;
    bw_d    = bw_q;
    ok_d    = ok_q;
    to_d    = to_q;
    finish  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_TX;
          cnt_d   = '0;
          tx_d    = {2'b01, cmd_idx, cmd_arg};
          len_d   = resp_len_m1;
          skip_d  = opt_skip_crc;
          from8_d = opt_crc_from8;
          bw_d    = opt_busy_wait;
          ok_d    = 1'b0;
          to_d    = 1'b0;
        end
      end
      S_TX: begin
        tx_d = {tx_q[HDR_BITS-2:0], 1'b0};
        if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
          state_d = S_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_WAIT: begin
        if (!cmd_in) begin
          state_d = S_RX;
          cnt_d   = CNT_W'(1);
        end else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) begin
          to_d    = 1'b1;
          finish  = 1'b1;
          state_d = S_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_RX: begin
        if (cnt_q == CNT_W'(len_q)) begin
          ok_d    = skip_q | (crc_q == '0);
          state_d = bw_q ? S_BUSY : S_IDLE;
          finish  = !bw_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_BUSY: begin
        if (dat0_in) begin
          finish  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    irq_d = finish ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      tx_q    <= '0;
      len_q   <= '0;
      skip_q  <= 1'b0;
      from8_q <= 1'b0;
      bw_q    <= 1'b0;
      ok_q    <= 1'b0;
      to_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
      len_q   <= len_d;
      skip_q  <= skip_d;
      from8_q <= from8_d;
      bw_q    <= bw_d;
      ok_q    <= ok_d;
      to_q    <= to_d;
      irq_q   <= irq_d;
    end
  end

  // line drive
  always_comb begin
    cmd_oe  = (state_q == S_TX);
    cmd_out = 1'b1;
    if (state_q == S_TX) begin
      if (cnt_q < CNT_W'(HDR_BITS))              cmd_out = tx_q[HDR_BITS-1];
      else if (cnt_q < CNT_W'(HDR_BITS + CRC_W)) cmd_out = crc_q[CRC_W-1];
    end
  end

  assign st_busy    = (state_q != S_IDLE);
  assign st_crc_ok  = ok_q;
  assign st_timeout = to_q;
  assign irq_done   = irq_q;
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk #(
  parameter int FRAME_BITS = 48
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_oe,
  input logic cmd_out,
  input logic st_busy,
  input logic st_timeout,
  input logic irq_done,
  input logic irq_clr
);
  logic [7:0] oe_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oe_run_q <= '0;
    else if (cmd_oe) oe_run_q <= oe_run_q + 1'b1;
    else             oe_run_q <= '0;
  end

  // R1: the line is only driven while a command is in progress
  a_r1_oe_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> st_busy);

  // R1: the driven stretch never exceeds one frame
  a_r1_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (oe_run_q < 8'(FRAME_BITS)));

  // R2: undriven line reads as high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out);

  // R8: interrupt holds until cleared
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !irq_clr) |=> irq_done);

  // R10: completion leaves the engine idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> !st_busy);

  // R3: timeout is reported together with the interrupt
  a_r3_timeout_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_timeout) |-> irq_done);
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_oe    (cmd_oe),
  .cmd_out   (cmd_out),
  .st_busy   (st_busy),
  .st_timeout(st_timeout),
  .irq_done  (irq_done),
  .irq_clr   (irq_clr)
);

// File: tb/sdcmd_engine_bench.sv
module sdcmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, opt_skip_crc, opt_crc_from8, opt_busy_wait;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic [7:0]  resp_len_m1;
  logic        irq_clr, resp_ptr_clr, resp_rd;
  logic [31:0] resp_word;
  logic        cmd_out, cmd_oe, cmd_in, dat0_in;
  logic        st_busy, st_crc_ok, st_timeout, irq_done;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 1'b0;
  bit [0:135] rb;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcmd_engine u_sdcmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .resp_len_m1(resp_len_m1), .opt_skip_crc(opt_skip_crc), .opt_crc_from8(opt_crc_from8),
    .opt_busy_wait(opt_busy_wait), .irq_clr(irq_clr), .resp_ptr_clr(resp_ptr_clr),
    .resp_rd(resp_rd), .resp_word(resp_word), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_in(cmd_in), .dat0_in(dat0_in), .st_busy(st_busy), .st_crc_ok(st_crc_ok),
    .st_timeout(st_timeout), .irq_done(irq_done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc_range(input int lo, input int hi);
    logic [6:0] c = '0;
    for (int j = lo; j <= hi; j++) c = crc_step(c, rb[j]);
    return c;
  endfunction

  task automatic build_short(input logic [5:0] idx, input logic [31:0] stat);
    logic [6:0] c;
    rb = '0;
    rb[0] = 1'b0; rb[1] = 1'b0;
    for (int j = 0; j < 6; j++)  rb[2+j] = idx[5-j];
    for (int j = 0; j < 32; j++) rb[8+j] = stat[31-j];
    c = crc_range(0, 39);
    for (int j = 0; j < 7; j++)  rb[40+j] = c[6-j];
    rb[47] = 1'b1;
  endtask

  task automatic build_long(input int seed);
    logic [6:0] c;
    int s = seed;
    rb = '0;
    for (int j = 2; j < 8; j++) rb[j] = 1'b1;
    for (int j = 8; j < 128; j++) begin
      s = s * 1103515245 + 12345;
      rb[j] = s[16];
    end
    c = crc_range(8, 127);
    for (int j = 0; j < 7; j++) rb[128+j] = c[6-j];
    rb[135] = 1'b1;
  endtask

  task automatic clear_irq();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    check(irq_done == 1'b0, "R8 clear", irq_done, 0);
  endtask

  // send: 1 = reply after gap, 0 = no reply (timeout path)
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] lm1,
                         input bit skip, input bit f8, input bit bw, input int gap,
                         input int bcyc, input bit send, input bit exp_ok, input int poke);
    logic [0:47] tx;
    logic [6:0]  c = '0;
    for (int j = 0; j < 40; j++) tx[j] = (j == 1) ? 1'b1 : (j == 0) ? 1'b0 :
                                         (j < 8) ? idx[7-j] : arg[39-j];
    for (int j = 0; j < 40; j++) c = crc_step(c, tx[j]);
    for (int j = 0; j < 7; j++) tx[40+j] = c[6-j];
    tx[47] = 1'b1;

    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; resp_len_m1 = lm1;
    opt_skip_crc = skip; opt_crc_from8 = f8; opt_busy_wait = bw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 48; i++) begin
      check(cmd_oe && st_busy, (i < 40) ? "R1 oe/busy" : "R2 oe/busy", {cmd_oe, st_busy}, 2'b11);
      check(cmd_out == tx[i], (i < 40) ? "R1 header bit" : "R2 crc/end bit", cmd_out, tx[i]);
      if (i == poke) begin
        start = 1'b1; cmd_idx = ~idx; cmd_arg = ~arg;  // R9 ignored start
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cmd_oe == 1'b0 && cmd_out == 1'b1, "R2 release", {cmd_oe, cmd_out}, 2'b01);
    if (send) begin
      if (bw) dat0_in = 1'b0;
      for (int g = 0; g < gap; g++) begin
        cmd_in = 1'b1;
        @(negedge clk);
      end
      for (int j = 0; j <= int'(lm1); j++) begin
        cmd_in = rb[j];
        @(negedge clk);
      end
      cmd_in = 1'b1;
      if (bw) begin
        for (int b = 0; b < bcyc; b++) begin
          check(irq_done == 1'b0 && st_busy, "R7 held", {irq_done, st_busy}, 2'b01);
          @(negedge clk);
        end
        dat0_in = 1'b1;
        @(negedge clk);
        check(irq_done == 1'b1, "R7 release", irq_done, 1);
      end
      check(irq_done == 1'b1 && st_busy == 1'b0, "R10 done", {irq_done, st_busy}, 2'b10);
      check(st_crc_ok == exp_ok, skip ? "R6 crc_ok" : "R5 crc_ok", st_crc_ok, exp_ok);
      check(st_timeout == 1'b0, "R3 no timeout", st_timeout, 0);
    end else begin
      for (int g = 0; g < 63; g++) begin
        cmd_in = 1'b1;
        @(negedge clk);
      end
      check(irq_done == 1'b0 && st_busy, "R3 window open", {irq_done, st_busy}, 2'b01);
      @(negedge clk);
      check(irq_done && st_timeout && !st_busy, "R3 timeout",
            {irq_done, st_timeout, st_busy}, 3'b110);
    end
  endtask

  task automatic read_words(input int lm1, input int nwords);
    logic [31:0] e;
    int p, j;
    @(negedge clk) resp_ptr_clr = 1'b1;
    @(negedge clk) resp_ptr_clr = 1'b0;
    for (int k = 0; k < nwords; k++) begin
      for (int b = 0; b < 32; b++) begin
        p = 32*k + 8 + b;
        j = lm1 - p;
        e[b] = (j >= 0) ? rb[j] : 1'b0;
      end
      check(resp_word == e, "R4 word", resp_word, e);
      resp_rd = 1'b1;
      @(negedge clk);
      resp_rd = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd_idx = '0; cmd_arg = '0; resp_len_m1 = '0;
    opt_skip_crc = 1'b0; opt_crc_from8 = 1'b0; opt_busy_wait = 1'b0;
    irq_clr = 1'b0; resp_ptr_clr = 1'b0; resp_rd = 1'b0; cmd_in = 1'b1; dat0_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check(!st_busy && !irq_done && !cmd_oe && cmd_out, "R10 reset",
          {st_busy, irq_done, cmd_oe, cmd_out}, 4'b0001);

    // short reply, good CRC, gap 2
    build_short(6'd17, 32'h0000_0900);
    run_cmd(6'd17, 32'h1234_5678, 8'd47, 0, 0, 0, 2, 0, 1, 1, -1);
    read_words(47, 1);
    // R8 sticky
    repeat (5) @(negedge clk);
    check(irq_done == 1'b1, "R8 sticky", irq_done, 1);
    clear_irq();

    // index 0, zero argument
    build_short(6'd0, 32'hDEAD_BEEF);
    run_cmd(6'd0, 32'h0, 8'd47, 0, 0, 0, 5, 0, 1, 1, -1);
    clear_irq();

    // all ones, plus R9 start pulse mid-frame
    build_short(6'd63, 32'hA5A5_0F0F);
    run_cmd(6'd63, 32'hFFFF_FFFF, 8'd47, 0, 0, 0, 1, 0, 1, 1, 10);
    check(st_busy == 1'b0, "R9 no second frame", st_busy, 0);
    @(negedge clk);
    check(cmd_oe == 1'b0 && st_busy == 1'b0, "R9 stays idle", {cmd_oe, st_busy}, 2'b00);
    clear_irq();

    // long reply, CRC from bit 8
    build_long(7);
    run_cmd(6'd2, 32'h0, 8'd135, 0, 1, 0, 3, 0, 1, 1, -1);
    read_words(135, 4);
    clear_irq();

    // same long reply, CRC from bit 0 -> bad
    run_cmd(6'd2, 32'h0, 8'd135, 0, 0, 0, 3, 0, 1, 0, -1);
    clear_irq();

    // corrupted CRC bit on short reply, then with skip
    build_short(6'd13, 32'h0000_0001);
    rb[43] = ~rb[43];
    run_cmd(6'd13, 32'h0001_0000, 8'd47, 0, 0, 0, 2, 0, 1, 0, -1);
    clear_irq();
    run_cmd(6'd13, 32'h0001_0000, 8'd47, 1, 0, 0, 2, 0, 1, 1, -1);
    clear_irq();

    // busy wait
    build_short(6'd7, 32'h0000_0700);
    run_cmd(6'd7, 32'h0002_0000, 8'd47, 0, 0, 1, 4, 10, 1, 1, -1);
    clear_irq();

    // start bit on the last accepted sample
    build_short(6'd55, 32'h0000_0120);
    run_cmd(6'd55, 32'h0000_0000, 8'd47, 0, 0, 0, 63, 0, 1, 1, -1);
    clear_irq();

    // no reply
    run_cmd(6'd9, 32'h0003_0000, 8'd47, 0, 0, 0, 0, 0, 0, 0, -1);
    clear_irq();
    check(st_timeout == 1'b1, "R3 timeout sticky until next start", st_timeout, 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule